// File: doc/BRIEF.md
# Control-Transfer and Trap Condition Unit

This purely combinational unit sits beside the execute stage of a 32-bit integer pipeline. It takes a decoded instruction's opcode, its register-immediate sub-opcode (the rt field), its function code, both source operand values, the already sign-extended 16-bit immediate, the 26-bit jump index and the address of the delay-slot instruction. From these it reports whether control transfers, where it transfers to, whether the return address must be written to the link register, whether the delay slot must be cancelled, and whether a conditional trap fires.

Inside, a decoder sorts the instruction into one of five kinds: none, conditional branch, absolute jump, register jump or trap. It also picks one of ten compare conditions and sets flags for the immediate operand, linking and the likely form. A shared comparator evaluates the chosen condition. A target generator forms both the PC-relative and the segment-absolute addresses. A final selection stage, driven by the kind, turns these into the five outputs. There is no clock. The house state-machine style is reduced here to an enumerated kind with one unique case for selecting the outputs.

Fetch redirection, exception vectoring and the register write itself belong to the surrounding pipeline.

Top module: `ctrl_xfer_unit`

## Requirements
- R1: Any opcode outside the control-transfer set (for example opcode 0x08) drives taken, link_en, nullify_slot and trap_req low and xfer_target to zero.
- R2: Opcode 0x04 is taken when rs equals rt, and opcode 0x05 when they differ. The target is slot_pc plus the sign-extended immediate shifted left by 2.
- R3: Opcode 0x06 is taken when rs is at most zero (signed), and opcode 0x07 when rs is greater than zero (signed). The target is the same PC-relative one.
- R4: Under opcode 0x01, rt codes 0x00 and 0x01 are taken when rs is negative and when rs is non-negative. Codes 0x10 and 0x11 behave the same way and also assert link_en whether or not the branch is taken.
- R5: The likely forms are opcodes 0x14 to 0x17, mirroring 0x04 to 0x07, and rt codes 0x02, 0x03, 0x12 and 0x13 under opcode 0x01, mirroring 0x00, 0x01, 0x10 and 0x11. They use the same conditions and targets. nullify_slot is high exactly when such a branch is not taken, and is never high for other instructions.
- R6: Opcode 0x02 is always taken, with target {slot_pc[31:28], jump_index, 2'b00}. Opcode 0x03 does the same and asserts link_en.
- R7: Opcode 0x00 with function 0x08 is always taken to the address in rs. Function 0x09 does the same and asserts link_en.
- R8: Opcode 0x00 with functions 0x30, 0x31, 0x32, 0x33, 0x34 and 0x36 asserts trap_req when rs >= rt signed, rs >= rt unsigned, rs < rt signed, rs < rt unsigned, rs == rt and rs != rt respectively.
- R9: Opcode 0x01 with rt codes 0x08, 0x09, 0x0A, 0x0B, 0x0C and 0x0E applies the same six trap compares against the sign-extended immediate instead of rt. The unsigned compares treat the extended immediate as an unsigned 32-bit value.
- R10: A trap instruction never asserts taken, link_en or nullify_slot. The unused codes (function 0x35 under opcode 0x00, rt code 0x0D under opcode 0x01) assert no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode | input | 6 | Primary opcode field |
| rt_code | input | 5 | rt field, used as sub-opcode under opcode 0x01 |
| funct | input | 6 | Function field, used under opcode 0x00 |
| rs_val | input | 32 | First source operand value |
| rt_val | input | 32 | Second source operand value |
| imm_sext | input | 32 | Sign-extended 16-bit immediate |
| jump_index | input | 26 | 26-bit absolute jump field |
| slot_pc | input | 32 | Address of the delay-slot instruction |
| taken | output | 1 | Control transfers to xfer_target |
| xfer_target | output | 32 | Destination address, zero when no transfer applies |
| link_en | output | 1 | Write the return address to the link register |
| nullify_slot | output | 1 | Cancel the delay-slot instruction |
| trap_req | output | 1 | Conditional trap fires |

## Verification
The unit holds no state. Any misdecoded kind or wrong compare selection shows up in the same evaluation as the instruction that causes it: a wrong taken, link or trap bit, or a target from the wrong generator. The checks therefore apply each encoding with operands on both sides of its boundary: zero versus the most negative value, and -1 against +1 so that signed and unsigned compares disagree. The outputs are read a few nanoseconds later.

// File: rtl/cxu_pkg.sv
package cxu_pkg;
    typedef enum logic [2:0] {
        K_NONE, K_BRANCH, K_JABS, K_JREG, K_TRAP
    } xfer_kind_e;

    typedef enum logic [3:0] {
        C_EQ, C_NE, C_LEZ, C_GTZ, C_LTZ, C_GEZ, C_GES, C_GEU, C_LTS, C_LTU
    } cond_sel_e;

    typedef struct packed {
        xfer_kind_e kind;
        cond_sel_e  cond;
        logic       use_imm;
        logic       link;
        logic       likely;
    } xfer_ctl_t;

    localparam logic [5:0] OP_SPECIAL = 6'h00;
    localparam logic [5:0] OP_REGIMM  = 6'h01;
    localparam logic [5:0] OP_JUMP    = 6'h02;
    localparam logic [5:0] OP_JLINK   = 6'h03;
endpackage

// File: rtl/cxu_decode.sv
module cxu_decode
    import cxu_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [4:0] rt_code,
    input  logic [5:0] funct,
    output xfer_ctl_t  ctl
);
    always_comb begin
        ctl = '{kind: K_NONE, cond: C_EQ, use_imm: 1'b0, link: 1'b0, likely: 1'b0};
        unique case (opcode)
            OP_SPECIAL: begin
                unique case (funct)
                    6'h08: ctl.kind = K_JREG;
                    6'h09: begin ctl.kind = K_JREG; ctl.link = 1'b1; end
                    6'h30: begin ctl.kind = K_TRAP; ctl.cond = C_GES; end
                    6'h31: begin ctl.kind = K_TRAP; ctl.cond = C_GEU; end
                    6'h32: begin ctl.kind = K_TRAP; ctl.cond = C_LTS; end
                    6'h33: begin ctl.kind = K_TRAP; ctl.cond = C_LTU; end
                    6'h34: begin ctl.kind = K_TRAP; ctl.cond = C_EQ;  end
                    6'h36: begin ctl.kind = K_TRAP; ctl.cond = C_NE;  end
                    default: ;
                endcase
            end
            OP_REGIMM: begin
                unique case (rt_code)
                    5'h00, 5'h01, 5'h02, 5'h03,
                    5'h10, 5'h11, 5'h12, 5'h13: begin
                        ctl.kind   = K_BRANCH;
                        ctl.cond   = rt_code[0] ? C_GEZ : C_LTZ;
                        ctl.likely = rt_code[1];
                        ctl.link   = rt_code[4];
                    end
                    5'h08: begin ctl.kind = K_TRAP; ctl.cond = C_GES; ctl.use_imm = 1'b1; end
                    5'h09: begin ctl.kind = K_TRAP; ctl.cond = C_GEU; ctl.use_imm = 1'b1; end
                    5'h0A: begin ctl.kind = K_TRAP; ctl.cond = C_LTS; ctl.use_imm = 1'b1; end
                    5'h0B: begin ctl.kind = K_TRAP; ctl.cond = C_LTU; ctl.use_imm = 1'b1; end
                    5'h0C: begin ctl.kind = K_TRAP; ctl.cond = C_EQ;  ctl.use_imm = 1'b1; end
                    5'h0E: begin ctl.kind = K_TRAP; ctl.cond = C_NE;  ctl.use_imm = 1'b1; end
                    default: ;
                endcase
            end
            OP_JUMP:  ctl.kind = K_JABS;
            OP_JLINK: begin ctl.kind = K_JABS; ctl.link = 1'b1; end
            6'h04, 6'h05, 6'h06, 6'h07,
            6'h14, 6'h15, 6'h16, 6'h17: begin
                ctl.kind   = K_BRANCH;
                ctl.likely = opcode[4];
                unique case (opcode[1:0])
                    2'd0: ctl.cond = C_EQ;
                    2'd1: ctl.cond = C_NE;
                    2'd2: ctl.cond = C_LEZ;
                    default: ctl.cond = C_GTZ;
                endcase
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cxu_compare.sv
module cxu_compare
    import cxu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    input  cond_sel_e         sel,
    output logic              hit
);
    logic lhs_neg, lhs_zero;
    assign lhs_neg  = lhs[DATA_W-1];
    assign lhs_zero = (lhs == '0);

    always_comb begin
        unique case (sel)
            C_EQ:    hit = (lhs == rhs);
            C_NE:    hit = (lhs != rhs);
            C_LEZ:   hit = lhs_neg | lhs_zero;
            C_GTZ:   hit = ~lhs_neg & ~lhs_zero;
            C_LTZ:   hit = lhs_neg;
            C_GEZ:   hit = ~lhs_neg;
            C_GES:   hit = ($signed(lhs) >= $signed(rhs));
            C_GEU:   hit = (lhs >= rhs);
            C_LTS:   hit = ($signed(lhs) < $signed(rhs));
            C_LTU:   hit = (lhs < rhs);
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/cxu_target.sv
module cxu_target #(
    parameter int DATA_W = 32,
    parameter int JIDX_W = 26
) (
    input  logic [DATA_W-1:0] slot_pc,
    input  logic [DATA_W-1:0] imm_sext,
    input  logic [JIDX_W-1:0] jump_index,
    output logic [DATA_W-1:0] rel_target,
    output logic [DATA_W-1:0] abs_target
);
    localparam int SEG_W = DATA_W - JIDX_W - 2;

    assign rel_target = slot_pc + {imm_sext[DATA_W-3:0], 2'b00};
    assign abs_target = {slot_pc[DATA_W-1 -: SEG_W], jump_index, 2'b00};
endmodule

// File: rtl/ctrl_xfer_unit.sv
module ctrl_xfer_unit
    import cxu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int JIDX_W = 26
) (
    input  logic [5:0]        opcode,
    input  logic [4:0]        rt_code,
    input  logic [5:0]        funct,
    input  logic [DATA_W-1:0] rs_val,
    input  logic [DATA_W-1:0] rt_val,
    input  logic [DATA_W-1:0] imm_sext,
    input  logic [JIDX_W-1:0] jump_index,
    input  logic [DATA_W-1:0] slot_pc,
    output logic              taken,
    output logic [DATA_W-1:0] xfer_target,
    output logic              link_en,
    output logic              nullify_slot,
    output logic              trap_req
);
    localparam int SEG_W = DATA_W - JIDX_W - 2;

    xfer_ctl_t         ctl;
    logic              cond_hit;
    logic [DATA_W-1:0] rhs_sel;
    logic [DATA_W-1:0] rel_target, abs_target;

    cxu_decode u_dec (
        .opcode (opcode),
        .rt_code(rt_code),
        .funct  (funct),
        .ctl    (ctl)
    );

    assign rhs_sel = ctl.use_imm ? imm_sext : rt_val;

    cxu_compare #(.DATA_W(DATA_W)) u_cmp (
        .lhs(rs_val),
        .rhs(rhs_sel),
        .sel(ctl.cond),
        .hit(cond_hit)
    );

    cxu_target #(.DATA_W(DATA_W), .JIDX_W(JIDX_W)) u_tgt (
        .slot_pc   (slot_pc),
        .imm_sext  (imm_sext),
        .jump_index(jump_index),
        .rel_target(rel_target),
        .abs_target(abs_target)
    );

    always_comb begin
        taken        = 1'b0;
        xfer_target  = '0;
        link_en      = 1'b0;
        nullify_slot = 1'b0;
        trap_req     = 1'b0;
        unique case (ctl.kind)
            K_BRANCH: begin
                taken        = cond_hit;
                xfer_target  = rel_target;
                link_en      = ctl.link;
                nullify_slot = ctl.likely & ~cond_hit;
            end
            K_JABS: begin
                taken       = 1'b1;
                xfer_target = abs_target;
                link_en     = ctl.link;
            end
            K_JREG: begin
                taken       = 1'b1;
                xfer_target = rs_val;
                link_en     = ctl.link;
            end
            K_TRAP:  trap_req = cond_hit;
            default: ;
        endcase
    end

    always_comb begin
        p_idle_quiet_r1: assert (opcode != 6'h08 ||
            (!taken && !link_en && !nullify_slot && !trap_req && xfer_target == '0))
            else $error("R1: non-control opcode drove an output");
        p_link_always_r4: assert (!(opcode == OP_REGIMM && rt_code == 5'h10) || link_en)
            else $error("R4: linking branch without link");
        p_nullify_excl_r5: assert (!(nullify_slot && taken))
            else $error("R5: nullify while taken");
        p_abs_jump_r6: assert (opcode != OP_JUMP ||
            (taken && xfer_target == {slot_pc[DATA_W-1 -: SEG_W], jump_index, 2'b00}))
            else $error("R6: absolute jump wrong");
        p_reg_jump_r7: assert (!(opcode == OP_SPECIAL && funct == 6'h08) ||
            (taken && xfer_target == rs_val))
            else $error("R7: register jump wrong");
        p_trap_quiet_r10: assert (!trap_req || (!taken && !link_en && !nullify_slot))
            else $error("R10: trap with transfer outputs");
    end
endmodule

// File: tb/tb_ctrl_xfer_unit.sv
module tb_ctrl_xfer_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  opcode;
    logic [4:0]  rt_code;
    logic [5:0]  funct;
    logic [31:0] rs_val, rt_val, imm_sext, slot_pc;
    logic [25:0] jump_index;
    logic        taken, link_en, nullify_slot, trap_req;
    logic [31:0] xfer_target;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ctrl_xfer_unit dut (
        .opcode(opcode), .rt_code(rt_code), .funct(funct),
        .rs_val(rs_val), .rt_val(rt_val), .imm_sext(imm_sext),
        .jump_index(jump_index), .slot_pc(slot_pc),
        .taken(taken), .xfer_target(xfer_target), .link_en(link_en),
        .nullify_slot(nullify_slot), .trap_req(trap_req)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic apply(input logic [5:0] op, input logic [4:0] rc, input logic [5:0] fn,
                         input logic [31:0] rs, input logic [31:0] rt, input logic [31:0] imm);
        @(negedge clk);
        opcode = op; rt_code = rc; funct = fn;
        rs_val = rs; rt_val = rt; imm_sext = imm;
        #3;
    endtask

    // expected: taken, target, link, nullify, trap
    task automatic expect_all(input string req, input logic t, input logic [31:0] tg,
                              input logic l, input logic n, input logic tr);
        chk(req, "taken", {31'b0, taken}, {31'b0, t});
        chk(req, "target", xfer_target, tg);
        chk(req, "link", {31'b0, link_en}, {31'b0, l});
        chk(req, "nullify", {31'b0, nullify_slot}, {31'b0, n});
        chk(req, "trap", {31'b0, trap_req}, {31'b0, tr});
    endtask

    task automatic t_idle_r1();
        apply(6'h08, 5'h00, 6'h00, 32'h1, 32'h1, 32'h4);
        expect_all("R1", 0, 32'h0, 0, 0, 0);
    endtask

    task automatic t_eq_ne_r2();
        slot_pc = 32'h0040_1000;
        apply(6'h04, 5'h0, 6'h0, 32'h55, 32'h55, 32'hFFFF_FFFC);
        expect_all("R2", 1, 32'h0040_0FF0, 0, 0, 0);
        apply(6'h04, 5'h0, 6'h0, 32'h55, 32'h56, 32'h10);
        expect_all("R2", 0, 32'h0040_1040, 0, 0, 0);
        apply(6'h05, 5'h0, 6'h0, 32'h55, 32'h56, 32'h10);
        expect_all("R2", 1, 32'h0040_1040, 0, 0, 0);
    endtask

    task automatic t_lez_gtz_r3();
        apply(6'h06, 5'h0, 6'h0, 32'h0, 32'h0, 32'h1);
        expect_all("R3", 1, 32'h0040_1004, 0, 0, 0);
        apply(6'h07, 5'h0, 6'h0, 32'h0, 32'h0, 32'h1);
        expect_all("R3", 0, 32'h0040_1004, 0, 0, 0);
        apply(6'h07, 5'h0, 6'h0, 32'h7FFF_FFFF, 32'h0, 32'h1);
        expect_all("R3", 1, 32'h0040_1004, 0, 0, 0);
        apply(6'h06, 5'h0, 6'h0, 32'h8000_0000, 32'h0, 32'h1);
        expect_all("R3", 1, 32'h0040_1004, 0, 0, 0);
    endtask

    task automatic t_regimm_r4();
        apply(6'h01, 5'h00, 6'h0, 32'h8000_0000, 32'h0, 32'h2);
        expect_all("R4", 1, 32'h0040_1008, 0, 0, 0);
        apply(6'h01, 5'h01, 6'h0, 32'h0, 32'h0, 32'h2);
        expect_all("R4", 1, 32'h0040_1008, 0, 0, 0);
        apply(6'h01, 5'h10, 6'h0, 32'h0, 32'h0, 32'h2);
        expect_all("R4", 0, 32'h0040_1008, 1, 0, 0);
        apply(6'h01, 5'h11, 6'h0, 32'hFFFF_FFFF, 32'h0, 32'h2);
        expect_all("R4", 0, 32'h0040_1008, 1, 0, 0);
    endtask

    task automatic t_likely_r5();
        apply(6'h14, 5'h0, 6'h0, 32'h1, 32'h2, 32'h3);
        expect_all("R5", 0, 32'h0040_100C, 0, 1, 0);
        apply(6'h15, 5'h0, 6'h0, 32'h1, 32'h2, 32'h3);
        expect_all("R5", 1, 32'h0040_100C, 0, 0, 0);
        apply(6'h17, 5'h0, 6'h0, 32'h0, 32'h0, 32'h3);
        expect_all("R5", 0, 32'h0040_100C, 0, 1, 0);
        apply(6'h01, 5'h12, 6'h0, 32'h5, 32'h0, 32'h3);
        expect_all("R5", 0, 32'h0040_100C, 1, 1, 0);
        apply(6'h01, 5'h03, 6'h0, 32'h5, 32'h0, 32'h3);
        expect_all("R5", 1, 32'h0040_100C, 0, 0, 0);
    endtask

    task automatic t_jabs_r6();
        slot_pc = 32'hA000_0004; jump_index = 26'h0123456;
        apply(6'h02, 5'h0, 6'h0, 32'h0, 32'h0, 32'h0);
        expect_all("R6", 1, 32'hA048_D158, 0, 0, 0);
        apply(6'h03, 5'h0, 6'h0, 32'h0, 32'h0, 32'h0);
        expect_all("R6", 1, 32'hA048_D158, 1, 0, 0);
    endtask

    task automatic t_jreg_r7();
        apply(6'h00, 5'h0, 6'h08, 32'h1234_5678, 32'h0, 32'h0);
        expect_all("R7", 1, 32'h1234_5678, 0, 0, 0);
        apply(6'h00, 5'h0, 6'h09, 32'hDEAD_BEE0, 32'h0, 32'h0);
        expect_all("R7", 1, 32'hDEAD_BEE0, 1, 0, 0);
    endtask

    task automatic t_rtrap_r8();
        apply(6'h00, 5'h0, 6'h30, 32'hFFFF_FFFF, 32'h1, 32'h0); expect_all("R8", 0, 0, 0, 0, 0);
        apply(6'h00, 5'h0, 6'h31, 32'hFFFF_FFFF, 32'h1, 32'h0); expect_all("R8", 0, 0, 0, 0, 1);
        apply(6'h00, 5'h0, 6'h32, 32'hFFFF_FFFF, 32'h1, 32'h0); expect_all("R8", 0, 0, 0, 0, 1);
        apply(6'h00, 5'h0, 6'h33, 32'hFFFF_FFFF, 32'h1, 32'h0); expect_all("R8", 0, 0, 0, 0, 0);
        apply(6'h00, 5'h0, 6'h34, 32'h7, 32'h7, 32'h0);         expect_all("R8", 0, 0, 0, 0, 1);
        apply(6'h00, 5'h0, 6'h36, 32'h7, 32'h7, 32'h0);         expect_all("R8", 0, 0, 0, 0, 0);
    endtask

    task automatic t_itrap_r9();
        apply(6'h01, 5'h08, 6'h0, 32'h5, 32'h0, 32'hFFFF_FFFB); expect_all("R9", 0, 0, 0, 0, 1);
        apply(6'h01, 5'h09, 6'h0, 32'h5, 32'h0, 32'hFFFF_FFFB); expect_all("R9", 0, 0, 0, 0, 0);
        apply(6'h01, 5'h0A, 6'h0, 32'h5, 32'h0, 32'hFFFF_FFFB); expect_all("R9", 0, 0, 0, 0, 0);
        apply(6'h01, 5'h0B, 6'h0, 32'h5, 32'h0, 32'hFFFF_FFFB); expect_all("R9", 0, 0, 0, 0, 1);
        apply(6'h01, 5'h0C, 6'h0, 32'hFFFF_FFFB, 32'h5, 32'hFFFF_FFFB); expect_all("R9", 0, 0, 0, 0, 1);
        apply(6'h01, 5'h0E, 6'h0, 32'h5, 32'h5, 32'hFFFF_FFFB); expect_all("R9", 0, 0, 0, 0, 1);
    endtask

    task automatic t_unused_r10();
        apply(6'h00, 5'h0, 6'h35, 32'h7, 32'h7, 32'h0);
        expect_all("R10", 0, 0, 0, 0, 0);
        apply(6'h01, 5'h0D, 6'h0, 32'h7, 32'h7, 32'h7);
        expect_all("R10", 0, 0, 0, 0, 0);
    endtask

    initial begin
        opcode = 6'h08; rt_code = '0; funct = '0; rs_val = '0; rt_val = '0;
        imm_sext = '0; jump_index = '0; slot_pc = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_idle_r1();
        t_eq_ne_r2();
        t_lez_gtz_r3();
        t_regimm_r4();
        t_likely_r5();
        t_jabs_r6();
        t_jreg_r7();
        t_rtrap_r8();
        t_itrap_r9();
        t_unused_r10();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule